// File: doc/BRIEF.md
# Serial EEPROM Instruction Word Fetcher

This block fetches one 10-bit instruction word at a time from a serial EEPROM on an SPI link. A host presents a 12-bit word address with a one-cycle start strobe. The block lowers the chip select and sends the read opcode and a 16-bit byte address. It then keeps clocking for sixteen more SCK cycles so that the memory streams out two consecutive bytes. The word comes back on a parallel output with a one-cycle valid strobe.

Each word takes two bytes in the memory, at byte address `2*word_address` and the byte after it. The memory shifts bytes out MSB-first, while the consuming bus wants bit 0 of the word first. The block therefore numbers the word bits in arrival order: the first data bit clocked in becomes word bit 0. The six trailing bits of the second byte are dropped. The EEPROM contents are written off-line, so the block only ever reads.

Top module: `spiw_fetch`

## Requirements
- R1: After reset, `cs_n_o` is 1, `sck_o` is 0 and `valid_o` is 0.
- R2: An accepted fetch sends exactly 40 SCK cycles with `cs_n_o` low. MOSI carries the opcode 0x03 MSB-first, then the 16-bit byte address equal to the word address times two, MSB-first. The last 16 cycles read data. `cs_n_o` then returns high.
- R3: SPI mode 0 applies. `sck_o` is low whenever `cs_n_o` is high. While the link is selected, MOSI changes only in the clock where `sck_o` falls. MISO is taken at the rising SCK edge.
- R4: The first data bit sampled after the address is word bit 0, and each later bit goes one position higher. Word bits 0..7 are therefore byte `2a` bits 7..0, and word bits 8 and 9 are byte `2a+1` bits 7 and 6.
- R5: The low six bits of the second byte have no effect on the word returned.
- R6: Each SCK period lasts exactly `CLK_DIV` system clocks (default 4 in the bench; at least 2 is required).
- R7: A start strobe has no effect while a fetch is in progress or during the deselect gap that follows it. No extra transaction occurs and the address already taken stays in use.
- R8: `valid_o` is high for exactly one clock per completed fetch, with `word_o` holding the assembled word in that clock.
- R9: Between transactions `cs_n_o` stays high for at least `CLK_DIV` system clocks.
- R10: Every word address from 0 to 4095 is reachable, including both ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Fetch request strobe |
| waddr_i | input | 12 | Word address, sampled with an accepted start |
| word_o | output | 10 | Fetched word, bit 0 is the first bit on the bus |
| valid_o | output | 1 | One-clock strobe marking `word_o` as new |
| sck_o | output | 1 | Serial clock to the EEPROM |
| mosi_o | output | 1 | Serial data to the EEPROM |
| cs_n_o | output | 1 | Active-low chip select |
| miso_i | input | 1 | Serial data from the EEPROM |

## Verification
A new start request and the completion of the current fetch can fall in the same clock. That is the clock where `valid_o` fires and the chip select rises. The bench provokes this collision by pulsing `start_i` exactly in the valid cycle, and also in the middle of a transfer. It then judges the outcome at the pins: no further chip-select fall may follow, and the scoreboard must not receive a word it did not queue. A back-to-back request, with start held through the gap, checks that the deselect time is kept and that the queued word still arrives in order.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_GAP  = 2'd2
   } fetch_state_t;

   localparam int OPCODE_BITS = 8;
   localparam int DATA_BITS   = 16;
endpackage

// File: rtl/spiw_sck_gen.sv
module spiw_sck_gen #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam int HALF = CLK_DIV / 2;

   logic [CW-1:0] phase_q;

   assign rise_tick = run && (phase_q == CW'(HALF - 1));
   assign fall_tick = run && (phase_q == CW'(CLK_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         sck     <= 1'b0;
      end else if (!run) begin
         phase_q <= '0;
         sck     <= 1'b0;
      end else begin
         phase_q <= fall_tick ? '0 : phase_q + 1'b1;
         if (rise_tick)      sck <= 1'b1;
         else if (fall_tick) sck <= 1'b0;
      end
   end

   // R6: a rising and a falling edge are never requested together
   a_r6_tick_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      rise_tick |-> !fall_tick);

   // R3: the serial clock is idle low whenever the divider is stopped
   a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sck);
endmodule

// File: rtl/spiw_word_capture.sv
module spiw_word_capture #(
   parameter int WORD_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic [3:0]        bit_idx,
   input  logic              miso,
   output logic [WORD_W-1:0] word
);
   // arrival order is word order: data bit k lands in word bit k
   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           word[i] <= 1'b0;
         else if (sample && bit_idx == 4'(i))  word[i] <= miso;
      end
   end

   // R5: samples past the word width leave the assembled word untouched
   a_r5_tail_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && bit_idx >= 4'(WORD_W)) |=> $stable(word));
endmodule

// File: rtl/spiw_fetch.sv
module spiw_fetch
   import spiw_pkg::*;
#(
   parameter int         ADDR_W  = 12,
   parameter int         WORD_W  = 10,
   parameter int         BADDR_W = 16,
   parameter int         CLK_DIV = 4,
   parameter logic [7:0] READ_OP = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] waddr_i,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o,
   output logic              sck_o,
   output logic              mosi_o,
   output logic              cs_n_o,
   input  logic              miso_i
);
   localparam int HDR_BITS   = OPCODE_BITS + BADDR_W;
   localparam int FRAME_BITS = HDR_BITS + DATA_BITS;
   localparam int BCW        = $clog2(FRAME_BITS);
   localparam int GW         = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

   if (CLK_DIV < 2) begin : g_bad_div
      $error("CLK_DIV must be at least 2");
   end
   if (WORD_W < 9 || WORD_W > DATA_BITS) begin : g_bad_word
      $error("WORD_W must span more than one byte and fit in two");
   end
   if (ADDR_W + 1 > BADDR_W) begin : g_bad_addr
      $error("byte address too narrow for word address");
   end

   fetch_state_t          state_q;
   logic [ADDR_W-1:0]     addr_q;
   logic [BCW-1:0]        bitcnt_q;
   logic [GW-1:0]         gap_q;
   logic [FRAME_BITS-1:0] frame;
   logic [WORD_W-1:0]     cap_word;
   logic                  rise_tick, fall_tick, sample, busy;
   logic [3:0]            data_idx;

   assign busy     = (state_q != ST_IDLE);
   assign frame    = {READ_OP, BADDR_W'({addr_q, 1'b0}), {DATA_BITS{1'b0}}};
   assign mosi_o   = !cs_n_o && frame[BCW'(FRAME_BITS - 1) - bitcnt_q];
   assign sample   = (state_q == ST_RUN) && rise_tick && (bitcnt_q >= BCW'(HDR_BITS));
   assign data_idx = 4'(bitcnt_q - BCW'(HDR_BITS));

   spiw_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (state_q == ST_RUN),
      .sck       (sck_o),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   spiw_word_capture #(.WORD_W(WORD_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .sample  (sample),
      .bit_idx (data_idx),
      .miso    (miso_i),
      .word    (cap_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         bitcnt_q <= '0;
         gap_q    <= '0;
         cs_n_o   <= 1'b1;
         valid_o  <= 1'b0;
         word_o   <= '0;
      end else begin
         valid_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               addr_q   <= waddr_i;
               bitcnt_q <= '0;
               cs_n_o   <= 1'b0;
               state_q  <= ST_RUN;
            end
            ST_RUN: if (fall_tick) begin
               if (bitcnt_q == BCW'(FRAME_BITS - 1)) begin
                  cs_n_o  <= 1'b1;
                  valid_o <= 1'b1;
                  word_o  <= cap_word;
                  gap_q   <= '0;
                  state_q <= ST_GAP;
               end else begin
                  bitcnt_q <= bitcnt_q + 1'b1;
               end
            end
            ST_GAP: begin
               gap_q <= gap_q + 1'b1;
               if (gap_q == GW'(CLK_DIV - 1)) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R8: the completion strobe never lasts two clocks
   a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R7: a request during a busy period does not replace the address in use
   a_r7_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i) |=> $stable(addr_q));

   // R3: while selected, serial output moves only together with a falling SCK
   a_r3_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && $past(!cs_n_o) && !$stable(mosi_o)) |-> $fell(sck_o));

   // R3: deselected link keeps SCK low
   a_r3_cs_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sck_o);

   // R9: a rising chip select is held for more than one clock
   a_r9_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |=> cs_n_o);
endmodule

// File: tb/tb_spiw_fetch.sv
module tb_spiw_fetch;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [11:0] waddr_i = '0;
   logic [9:0] word_o;
   logic       valid_o, sck_o, mosi_o, cs_n_o;
   logic       miso_i = 1'b0;

   int total = 0;
   int bad   = 0;
   int valids = 0;
   bit done = 1'b0;

   logic [9:0]  expq[$];
   logic [15:0] addrq[$];

   always #4 clk = ~clk;

   spiw_fetch #(.CLK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .waddr_i(waddr_i),
      .word_o(word_o), .valid_o(valid_o), .sck_o(sck_o), .mosi_o(mosi_o),
      .cs_n_o(cs_n_o), .miso_i(miso_i)
   );

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      logic [15:0] t;
      t = (a * 16'd29) ^ (a >> 5) ^ 16'h005A;
      return t[7:0];
   endfunction

   function automatic logic [9:0] exp_word(input logic [11:0] a);
      logic [7:0] b0, b1;
      logic [9:0] w;
      b0 = mem_byte({3'b0, a, 1'b0});
      b1 = mem_byte({3'b0, a, 1'b1});
      for (int i = 0; i < 8; i++) w[i] = b0[7-i];
      w[8] = b1[7];
      w[9] = b1[6];
      return w;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // ---------------- EEPROM model ----------------
   int          rcnt = 0;
   logic [7:0]  op_sh;
   logic [15:0] ad_sh;
   logic [15:0] base;

   always @(negedge cs_n_o) rcnt = 0;

   always @(posedge sck_o) begin
      if (!cs_n_o) begin
         if (rcnt < 8) op_sh = {op_sh[6:0], mosi_o};
         else if (rcnt < 24) ad_sh = {ad_sh[14:0], mosi_o};
         rcnt++;
         if (rcnt == 8) chk(op_sh == 8'h03, "R2 opcode", op_sh, 8'h03);
         if (rcnt == 24) begin
            base = ad_sh;
            if (addrq.size() == 0) chk(1'b0, "R7 unrequested transaction", ad_sh, 0);
            else begin
               logic [15:0] ea;
               ea = addrq.pop_front();
               chk(ad_sh == ea, "R2 byte address", ad_sh, ea);
            end
         end
      end
   end

   always @(negedge sck_o) begin
      if (!cs_n_o && rcnt >= 24 && rcnt < 40) begin
         logic [7:0] b;
         int k;
         k = rcnt - 24;
         b = mem_byte(base + 16'(k / 8));
         miso_i = b[7 - (k % 8)];
      end
   end

   // ---------------- monitor / scoreboard ----------------
   logic prev_valid = 0, prev_sck = 0, prev_cs = 1, prev_mosi = 0;
   int   hi_cnt = 0, per_cnt = 0, sck_rises = 0, tx_seen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_valid) chk(!valid_o, "R8 valid width", valid_o, 0);
         if (valid_o) begin
            valids++;
            chk(cs_n_o, "R2 cs raised at end", cs_n_o, 1);
            if (expq.size() == 0) chk(1'b0, "R7 unexpected word", word_o, 0);
            else begin
               logic [9:0] e;
               e = expq.pop_front();
               chk(word_o == e, "R4 R5 word bit order", word_o, e);
            end
         end
         if (cs_n_o && sck_o) chk(1'b0, "R3 sck low when deselected", sck_o, 0);
         if (!cs_n_o && !prev_cs && mosi_o != prev_mosi)
            chk(prev_sck && !sck_o, "R3 mosi moves on fall", {prev_sck, sck_o}, 2);
         if (!prev_cs && cs_n_o)
            chk(sck_rises == 40, "R2 clock count", sck_rises, 40);
         if (cs_n_o) hi_cnt++;
         if (prev_cs && !cs_n_o) begin
            if (tx_seen > 0) chk(hi_cnt >= DIV, "R9 deselect gap", hi_cnt, DIV);
            tx_seen++;
            sck_rises = 0;
            per_cnt = 0;
         end
         if (!cs_n_o) begin
            per_cnt++;
            if (sck_o && !prev_sck) begin
               if (sck_rises > 0) chk(per_cnt == DIV, "R6 sck period", per_cnt, DIV);
               sck_rises++;
               per_cnt = 0;
            end
         end
         if (!cs_n_o) hi_cnt = 0;
         prev_valid = valid_o;
         prev_sck   = sck_o;
         prev_cs    = cs_n_o;
         prev_mosi  = mosi_o;
      end
   end

   // ---------------- driver ----------------
   task automatic fetch(input logic [11:0] a);
      while (!cs_n_o) @(negedge clk);
      expq.push_back(exp_word(a));
      addrq.push_back({3'b0, a, 1'b0});
      start_i = 1'b1;
      waddr_i = a;
      do @(negedge clk); while (cs_n_o);
      start_i = 1'b0;
      waddr_i = ~a;
   endtask

   task automatic wait_valid();
      do @(negedge clk); while (!valid_o);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cs_n_o == 1'b1, "R1 cs_n reset", cs_n_o, 1);
      chk(sck_o == 1'b0, "R1 sck reset", sck_o, 0);
      chk(valid_o == 1'b0, "R1 valid reset", valid_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 address range ends and assorted patterns
      fetch(12'h000); wait_valid();
      fetch(12'hFFF); wait_valid();
      fetch(12'h800); wait_valid();
      fetch(12'h555); wait_valid();
      fetch(12'h2AA); wait_valid();
      fetch(12'h07F);

      // R7: pulse start mid-transfer
      repeat (40) @(negedge clk);
      start_i = 1'b1; waddr_i = 12'h123;
      @(negedge clk);
      start_i = 1'b0;
      // R7: pulse start in the very valid cycle
      while (!valid_o) begin
         @(negedge clk);
      end
      // valid_o observed at this negedge: raise start so the next edge sees it
      start_i = 1'b1; waddr_i = 12'h321;
      @(negedge clk);
      start_i = 1'b0;
      repeat (60) @(negedge clk);
      chk(cs_n_o == 1'b1, "R7 no transaction after ignored start", cs_n_o, 1);
      chk(valids == 6, "R7 word count after ignored starts", valids, 6);

      // R9: back-to-back requests with start held through the gap
      fetch(12'h3C5);
      fetch(12'hABC); wait_valid();
      repeat (20) @(negedge clk);
      chk(expq.size() == 0, "R8 all words delivered", expq.size(), 0);
      chk(valids == 8, "R8 one valid per fetch", valids, 8);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule